// File: doc/BRIEF.md
# Sleep Timer Capture and Restore Register

This block keeps a 10-bit copy of a radio's fine counter in logic that stays powered while the radio sleeps. When the radio core signals entry into deep sleep, the block samples the live counter value by itself. When the radio core signals wake-up, the block sends the held value back to the counter together with a one-cycle restore strobe, so the counter resumes where it stopped.

While the radio sleeps, software reaches the held value through a small 16-bit register port with two locations. Location 0 is the held value. Location 1 is a 2-bit read-select field that chooses what a read of location 0 returns: the held value, or one of the sleep-duration and sleep-status debug fields that the radio core provides. Software writes to location 0 take effect only while the radio sleeps. Each write is staged for one cycle before it commits, so a read-back needs one idle cycle after the write.

Top module: `sleep_cnt_keeper`

## Requirements
- R1: After a synchronous reset the held value is 0, the read-select field is 0, the radio is taken as awake, reg_rdata is 0 and restore_stb is 0.
- R2: A sleep_enter_stb pulse while awake loads fine_cnt into the held value and marks the radio asleep. A sleep_enter_stb pulse while already asleep changes nothing.
- R3: A wake_stb pulse while asleep marks the radio awake, and in the next cycle restore_stb is 1 for exactly one cycle with restore_val equal to the held value. A wake_stb pulse while awake produces no restore_stb.
- R4: A write to location 0 (reg_addr = 0) issued while the radio is awake leaves the held value unchanged.
- R5: A write to location 0 while asleep puts reg_wdata[9:0] into the held value. A read issued two or more cycles after the write returns the new value, and a read issued in the cycle right after the write returns the previous value. A write is dropped if wake_stb arrives in the cycle that follows it.
- R6: When a write to location 0 and an automatic capture fall in the same cycle, the held value takes fine_cnt.
- R7: A read of location 0 returns, by read-select value: 0 the held value; 1 dbg_sleep_dur[9:0]; 2 dbg_sleep_time[9:0]; 3 {dbg_sleep_stat, dbg_sleep_time[18:10]} with the status in bit 9. Writes to location 0 act the same for every read-select value.
- R8: reg_rdata changes only in the cycle after a cycle with reg_rd = 1, and its bits 15:10 are always 0.
- R9: A write to location 1 (reg_addr = 1) stores reg_wdata[1:0] as the read-select field at any time, and a read of location 1 returns it in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 1 | Location: 0 held value, 1 read-select field |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe, data appears one cycle later |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| sleep_enter_stb | input | 1 | One-cycle pulse: radio enters deep sleep |
| wake_stb | input | 1 | One-cycle pulse: radio wakes up |
| fine_cnt | input | 10 | Live radio fine counter |
| dbg_sleep_dur | input | 10 | Sleep-duration debug value |
| dbg_sleep_time | input | 19 | Sampled sleep-time debug value |
| dbg_sleep_stat | input | 1 | Sleep-status monitor bit |
| restore_stb | output | 1 | One-cycle pulse carrying the restore value |
| restore_val | output | 10 | Value to load back into the fine counter |

## Verification
The hardest situations to reach are those where a software access meets a radio event within a cycle or two: a write in the cycle of a capture, a write followed at once by wake, and a read in the cycle right after a write. Random stimulus makes the radio sleep in short stretches so that writes and reads fall near the strobes often, and directed sequences place each of those coincidences on an exact cycle. A cycle model in the bench, built from the requirements, predicts every read and restore.

// File: rtl/sck_pkg.sv
package sck_pkg;
  // Read-select encoding for location 0 reads
  typedef enum logic [1:0] {
    SEL_HELD = 2'd0,
    SEL_DUR  = 2'd1,
    SEL_TLO  = 2'd2,
    SEL_THI  = 2'd3
  } rd_sel_e;

  localparam int SEL_W = 2;

  // Register locations
  localparam logic LOC_HELD = 1'b0;
  localparam logic LOC_SEL  = 1'b1;
endpackage

// File: rtl/sck_sleep_seq.sv
// Tracks the radio sleep state and generates the one-cycle restore strobe.
module sck_sleep_seq (
  input  logic clk,
  input  logic rst,
  input  logic sleep_enter_stb,
  input  logic wake_stb,
  output logic asleep_q,
  output logic capture,
  output logic wake_hit,
  output logic restore_stb_q
);
  assign capture  = sleep_enter_stb && !asleep_q;
  assign wake_hit = wake_stb && asleep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      asleep_q      <= 1'b0;
      restore_stb_q <= 1'b0;
    end else begin
      restore_stb_q <= wake_hit;
      if (capture)
        asleep_q <= 1'b1;
      else if (wake_hit)
        asleep_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sck_hold.sv
// Holds the counter copy: capture, staged software write, restore value.
module sck_hold #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [CNT_W-1:0] fine_cnt,
  input  logic             asleep,
  input  logic             wake_hit,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] held_q,
  output logic [CNT_W-1:0] restore_val_q
);
  logic             pend_q;
  logic [CNT_W-1:0] stage_q;
  logic             commit;

  // A staged write commits one cycle later, only if still asleep and not waking
  assign commit = pend_q && asleep && !wake_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q        <= 1'b0;
      stage_q       <= '0;
      held_q        <= '0;
      restore_val_q <= '0;
    end else begin
      pend_q <= wr_en && asleep && !capture;
      if (wr_en)
        stage_q <= wdata;
      if (capture)
        held_q <= fine_cnt;
      else if (commit)
        held_q <= stage_q;
      if (wake_hit)
        restore_val_q <= held_q;
    end
  end
endmodule

// File: rtl/sck_rdmux.sv
// Registered read-back multiplexer.
module sck_rdmux
  import sck_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int TIME_W = 19,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              addr,
  input  rd_sel_e           sel,
  input  logic [CNT_W-1:0]  held,
  input  logic [CNT_W-1:0]  dur,
  input  logic [TIME_W-1:0] stime,
  input  logic              stat,
  output logic [REG_W-1:0]  rdata_q
);
  localparam int HI_W = TIME_W - CNT_W;

  logic [CNT_W-1:0] field;
  logic [REG_W-1:0] next_rd;

  always_comb begin
    unique case (sel)
      SEL_HELD: field = held;
      SEL_DUR:  field = dur;
      SEL_TLO:  field = stime[CNT_W-1:0];
      default:  field = CNT_W'({stat, stime[TIME_W-1:CNT_W]});
    endcase
    if (addr == LOC_SEL)
      next_rd = REG_W'(sel);
    else
      next_rd = REG_W'(field);
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (rd)
      rdata_q <= next_rd;
  end

  initial begin
    if (HI_W + 1 > CNT_W)
      $error("sleep time upper field wider than the held value");
  end
endmodule

// File: rtl/sleep_cnt_keeper.sv
module sleep_cnt_keeper
  import sck_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int TIME_W = 19,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              sleep_enter_stb,
  input  logic              wake_stb,
  input  logic [CNT_W-1:0]  fine_cnt,
  input  logic [CNT_W-1:0]  dbg_sleep_dur,
  input  logic [TIME_W-1:0] dbg_sleep_time,
  input  logic              dbg_sleep_stat,
  output logic              restore_stb,
  output logic [CNT_W-1:0]  restore_val
);
  logic             asleep_q;
  logic             capture;
  logic             wake_hit;
  logic [CNT_W-1:0] held_q;
  rd_sel_e          sel_q;
  logic             unused_wbits;

  assign unused_wbits = ^reg_wdata[REG_W-1:CNT_W];

  always_ff @(posedge clk) begin
    if (rst)
      sel_q <= SEL_HELD;
    else if (reg_wr && reg_addr == LOC_SEL)
      sel_q <= rd_sel_e'(reg_wdata[SEL_W-1:0]);
  end

  sck_sleep_seq u_seq (
    .clk             (clk),
    .rst             (rst),
    .sleep_enter_stb (sleep_enter_stb),
    .wake_stb        (wake_stb),
    .asleep_q        (asleep_q),
    .capture         (capture),
    .wake_hit        (wake_hit),
    .restore_stb_q   (restore_stb)
  );

  sck_hold #(.CNT_W(CNT_W)) u_hold (
    .clk           (clk),
    .rst           (rst),
    .capture       (capture),
    .fine_cnt      (fine_cnt),
    .asleep        (asleep_q),
    .wake_hit      (wake_hit),
    .wr_en         (reg_wr && reg_addr == LOC_HELD),
    .wdata         (reg_wdata[CNT_W-1:0]),
    .held_q        (held_q),
    .restore_val_q (restore_val)
  );

  sck_rdmux #(.CNT_W(CNT_W), .TIME_W(TIME_W), .REG_W(REG_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd      (reg_rd),
    .addr    (reg_addr),
    .sel     (sel_q),
    .held    (held_q),
    .dur     (dbg_sleep_dur),
    .stime   (dbg_sleep_time),
    .stat    (dbg_sleep_stat),
    .rdata_q (reg_rdata)
  );
endmodule

// File: rtl/sck_checker.sv
module sck_checker #(
  parameter int CNT_W = 10,
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sleep_enter_stb,
  input logic             wake_stb,
  input logic [CNT_W-1:0] fine_cnt,
  input logic             asleep_q,
  input logic [CNT_W-1:0] held_q,
  input logic             reg_rd,
  input logic [REG_W-1:0] reg_rdata,
  input logic             restore_stb,
  input logic [CNT_W-1:0] restore_val
);
  // R3: restore strobe lasts one cycle
  a_r3_restore_single: assert property (@(posedge clk) disable iff (rst)
    restore_stb |=> !restore_stb);

  // R3: restore strobe follows a wake strobe
  a_r3_restore_after_wake: assert property (@(posedge clk) disable iff (rst)
    restore_stb |-> $past(wake_stb));

  // R3: restored value is the held value at wake time
  a_r3_restore_value: assert property (@(posedge clk) disable iff (rst)
    restore_stb |-> restore_val == $past(held_q));

  // R2: capture loads the live counter
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    (sleep_enter_stb && !asleep_q) |=> held_q == $past(fine_cnt));

  // R4: held value is untouched while awake unless captured
  a_r4_awake_stable: assert property (@(posedge clk) disable iff (rst)
    (!asleep_q && !sleep_enter_stb) |=> held_q == $past(held_q));

  // R8: read data moves only after a read strobe
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind sleep_cnt_keeper sck_checker #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .sleep_enter_stb (sleep_enter_stb),
  .wake_stb        (wake_stb),
  .fine_cnt        (fine_cnt),
  .asleep_q        (asleep_q),
  .held_q          (held_q),
  .reg_rd          (reg_rd),
  .reg_rdata       (reg_rdata),
  .restore_stb     (restore_stb),
  .restore_val     (restore_val)
);

// File: tb/tb_sleep_cnt_keeper.sv
module tb_sleep_cnt_keeper;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_addr, reg_wr, reg_rd;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        sleep_enter_stb, wake_stb;
  logic [9:0]  fine_cnt, dbg_sleep_dur;
  logic [18:0] dbg_sleep_time;
  logic        dbg_sleep_stat;
  logic        restore_stb;
  logic [9:0]  restore_val;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [9:0] m_held;
  logic [1:0] m_sel;
  logic       m_asleep;
  logic       m_pend;
  logic [9:0] m_stage;

  always #5 clk = ~clk;

  sleep_cnt_keeper dut (.*);

  function automatic logic [15:0] exp_read(logic a, logic [1:0] s, logic [9:0] h,
                                           logic [9:0] d, logic [18:0] t, logic st);
    if (a) return {14'd0, s};
    case (s)
      2'd0:    return {6'd0, h};
      2'd1:    return {6'd0, d};
      2'd2:    return {6'd0, t[9:0]};
      default: return {6'd0, st, t[18:10]};
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, predict, clock, compare at next negedge
  task automatic step(logic en, logic wk, logic wr, logic rd, logic a,
                      logic [15:0] wd, string tag);
    logic [15:0] e_rd;
    logic        e_rs;
    logic [9:0]  e_rv;
    logic        cap, wh, cmt;
    sleep_enter_stb = en; wake_stb = wk; reg_wr = wr; reg_rd = rd;
    reg_addr = a; reg_wdata = wd;
    cap  = en && !m_asleep;
    wh   = wk && m_asleep;
    cmt  = m_pend && m_asleep && !wk;
    e_rs = wh;
    e_rv = m_held;
    e_rd = exp_read(a, m_sel, m_held, dbg_sleep_dur, dbg_sleep_time, dbg_sleep_stat);
    @(posedge clk);
    @(negedge clk);
    check("R3 restore_stb", {15'd0, restore_stb}, {15'd0, e_rs});
    if (e_rs) check("R3 restore_val", {6'd0, restore_val}, {6'd0, e_rv});
    if (rd) begin
      check(tag, reg_rdata, e_rd);
      check("R8 upper bits", {10'd0, reg_rdata[15:10]}, 16'd0);
    end
    if (cap) m_held = fine_cnt;
    else if (cmt) m_held = m_stage;
    m_pend = wr && !a && m_asleep && !cap;
    if (wr && !a) m_stage = wd[9:0];
    if (wr && a) m_sel = wd[1:0];
    if (cap) m_asleep = 1'b1;
    else if (wh) m_asleep = 1'b0;
    sleep_enter_stb = 0; wake_stb = 0; reg_wr = 0; reg_rd = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 16'h0, "idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rst = 1; reg_addr = 0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
    sleep_enter_stb = 0; wake_stb = 0; fine_cnt = 0;
    dbg_sleep_dur = 10'h123; dbg_sleep_time = 19'h5A5A5; dbg_sleep_stat = 1;
    m_held = 0; m_sel = 0; m_asleep = 0; m_pend = 0; m_stage = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rdata after reset", reg_rdata, 16'd0);
    check("R1 restore_stb after reset", {15'd0, restore_stb}, 16'd0);
    rst = 0;
    step(0, 0, 0, 1, 0, 16'h0, "R1 held read");
    step(0, 0, 0, 1, 1, 16'h0, "R1 select read");

    // R4: write while awake dropped
    step(0, 0, 1, 0, 0, 16'h0155, "R4 write");
    idle(2);
    step(0, 0, 0, 1, 0, 16'h0, "R4 held unchanged");

    // R2: capture, then second enter ignored
    fine_cnt = 10'h2AA;
    step(1, 0, 0, 0, 0, 16'h0, "R2 enter");
    fine_cnt = 10'h111;
    step(0, 0, 0, 1, 0, 16'h0, "R2 captured");
    step(1, 0, 0, 0, 0, 16'h0, "R2 enter while asleep");
    step(0, 0, 0, 1, 0, 16'h0, "R2 no recapture");

    // R5: write, read at once (old), read later (new)
    step(0, 0, 1, 0, 0, 16'hFCF0, "R5 write");
    step(0, 0, 0, 1, 0, 16'h0, "R5 hazard read old");
    step(0, 0, 0, 1, 0, 16'h0, "R5 read new");

    // R9 / R7: select field and each mux leg, data write under sel 2
    for (int s = 1; s < 4; s++) begin
      step(0, 0, 1, 0, 1, 16'hFFF0 | 16'(s), "R9 select write");
      step(0, 0, 0, 1, 1, 16'h0, "R9 select read");
      step(0, 0, 0, 1, 0, 16'h0, "R7 mux field");
    end
    step(0, 0, 1, 0, 1, 16'h0002, "R9 select write");
    step(0, 0, 1, 0, 0, 16'h0077, "R7 write under sel 2");
    step(0, 0, 1, 0, 1, 16'h0000, "R9 select write");
    idle(1);
    step(0, 0, 0, 1, 0, 16'h0, "R7 write independent of select");

    // R3: wake restores, wake while awake ignored
    step(0, 1, 0, 0, 0, 16'h0, "R3 wake");
    idle(1);
    step(0, 1, 0, 0, 0, 16'h0, "R3 wake while awake");
    idle(1);

    // R6: write and capture same cycle
    fine_cnt = 10'h3C3;
    step(1, 0, 1, 0, 0, 16'h0021, "R6 collide");
    idle(1);
    step(0, 0, 0, 1, 0, 16'h0, "R6 capture wins");

    // R5: write then wake next cycle is dropped
    step(0, 0, 1, 0, 0, 16'h0099, "R5 write before wake");
    step(0, 1, 0, 0, 0, 16'h0, "R5 wake drops staged write");
    idle(1);
    step(0, 0, 0, 1, 0, 16'h0, "R5 dropped write");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      fine_cnt       = 10'($urandom);
      dbg_sleep_dur  = 10'($urandom);
      dbg_sleep_time = 19'($urandom);
      dbg_sleep_stat = 1'($urandom);
      r = int'($urandom % 100);
      step(r < 6, (r >= 6 && r < 12), ($urandom % 100) < 30,
           ($urandom % 100) < 45, ($urandom % 100) < 20,
           16'($urandom), "R7 random read");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule